// File: doc/BRIEF.md
# Thermal Watchdog Alarm Output Controller

This block decides, after each temperature conversion, whether an overtemperature alarm should be asserted. It takes an 11-bit two's complement temperature sample, qualified by a one-cycle valid strobe. It keeps the upper nine bits of the sample (0.5 °C per step) and compares them as signed values against two 9-bit two's complement limits: a high trip point and a lower hysteresis point. The result drives a logical alarm flag and an enable for the pull-down of an open-drain pin.

Two alarm behaviours are available. In thermostat mode the alarm sets once the temperature has been above the trip point, and clears once it has been under the hysteresis point. In latched mode the alarm alternates between a trip-point trigger and a hysteresis-point trigger, and each alarm is held until a register read or the shutdown bit clears it. In both modes a transition needs a programmable number of consecutive qualifying conversions. Limit and configuration registers live outside this block, and their reset values are set there: trip 0x0A0 (80 °C), hysteresis 0x096 (75 °C), thermostat mode, one fault, active low.

The sample input is a valid-only stream. The block accepts a sample on every cycle and never applies back-pressure, so it has no ready signal. A sample presented while shutdown is set is discarded. All other pins are plain level or pulse controls.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset, `alarm` is 0, the next latched-mode trigger is the trip point, and with `cfg_active_high`=0 `pin_pull_low` is 0.
- R2: Comparison uses `conv_temp[10:2]` as a signed 9-bit value. "Above" means strictly greater than `lim_high`, and "under" means strictly less than `lim_hyst`. A sample equal to a limit does not qualify. Only cycles with `conv_valid`=1 are evaluated, and the outputs change only in the cycle after such a strobe, a read, or shutdown.
- R3: In thermostat mode (`cfg_latch_mode`=0) with `alarm`=0, the alarm sets on the clock edge of the Nth consecutive sample above `lim_high`.
- R4: In thermostat mode with `alarm`=1, the alarm clears on the clock edge of the Nth consecutive sample under `lim_hyst`.
- R5: In thermostat mode, `reg_read` and `cfg_shutdown` never change `alarm`.
- R6: N comes from `cfg_fault_code`: 00→1, 01→2, 10→4, 11→6. A sample that is evaluated but does not meet the condition currently in force restarts the count at zero.
- R7: In latched mode (`cfg_latch_mode`=1) the trigger in force starts as "above `lim_high`". Each time the alarm sets, the trigger switches to "under `lim_hyst`", and the next time it switches back. An active alarm clears in the cycle after `reg_read`=1 or `cfg_shutdown`=1.
- R8: In latched mode, while `alarm`=1, samples have no effect and the alarm stays set until cleared.
- R9: `pin_pull_low` is 1 when `alarm`=1 and `cfg_active_high`=0, or when `alarm`=0 and `cfg_active_high`=1. Otherwise it is 0. It follows the polarity bit without delay.
- R10: A change of `cfg_latch_mode` zeroes the fault count and re-arms the trip-point trigger. The alarm keeps its value, and a sample in that same cycle is discarded.
- R11: Samples presented while `cfg_shutdown`=1 are discarded in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle strobe qualifying `conv_temp` |
| conv_temp | input | 11 | Two's complement temperature, 0.125 °C per LSB |
| lim_high | input | 9 | Trip point, two's complement, 0.5 °C per LSB |
| lim_hyst | input | 9 | Hysteresis point, two's complement, 0.5 °C per LSB |
| cfg_latch_mode | input | 1 | 0 thermostat mode, 1 latched mode |
| cfg_active_high | input | 1 | 0 pin active low, 1 pin active high |
| cfg_fault_code | input | 2 | Consecutive-fault code |
| reg_read | input | 1 | Pulse for any register read |
| cfg_shutdown | input | 1 | Shutdown level |
| alarm | output | 1 | Logical alarm state |
| pin_pull_low | output | 1 | Enables the open-drain pull-down |

## Verification
The assertions check, on every cycle:
- the alarm moves only after a strobe, read or shutdown;
- thermostat mode ignores reads and shutdown, and never sets without an above-trip sample;
- in latched mode a read or shutdown clears an active alarm, and with neither the alarm is held.

Some behaviours depend on history and only the bench scenarios can show them:
- the fault-queue counts and their restart on a miss;
- the alternation of the latched-mode trigger;
- strict equality at both limits, and signed comparison of negative temperatures;
- truncation of the two low temperature bits;
- the count reset on a mode change.

// File: rtl/talm_pkg.sv
package talm_pkg;
  localparam int CNT_W = 3;

  // Consecutive-fault code to required count.
  function automatic logic [CNT_W-1:0] fault_need(input logic [1:0] code);
    case (code)
      2'b00:   fault_need = CNT_W'(1);
      2'b01:   fault_need = CNT_W'(2);
      2'b10:   fault_need = CNT_W'(4);
      default: fault_need = CNT_W'(6);
    endcase
  endfunction
endpackage

// File: rtl/talm_limit_cmp.sv
module talm_limit_cmp #(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9
) (
  input  logic [TEMP_W-1:0] temp,
  input  logic [LIM_W-1:0]  hi,
  input  logic [LIM_W-1:0]  lo,
  output logic              above,
  output logic              under
);
  localparam int DROP = TEMP_W - LIM_W;
  logic [LIM_W-1:0] coarse;

  generate
    if (DROP > 0) begin : g_trunc
      assign coarse = temp[TEMP_W-1:DROP];
    end else begin : g_same
      assign coarse = temp[LIM_W-1:0];
    end
  endgenerate

  assign above = $signed(coarse) > $signed(hi);
  assign under = $signed(coarse) < $signed(lo);
endmodule

// File: rtl/talm_fault_count.sv
module talm_fault_count #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qualify,
  input  logic             hit,
  input  logic             force_clr,
  input  logic [CNT_W-1:0] need,
  output logic             reached
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign reached  = qualify && hit && (next_cnt >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (force_clr) begin
      cnt <= '0;
    end else if (qualify) begin
      if (hit && !reached) cnt <= next_cnt[CNT_W-1:0];
      else                 cnt <= '0;
    end
  end
endmodule

// File: rtl/talm_alarm_state.sv
module talm_alarm_state (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic latch_clr,
  input  logic rearm,
  input  logic latch_mode,
  output logic alarm_q,
  output logic arm_under
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q   <= 1'b0;
      arm_under <= 1'b0;
    end else begin
      if (latch_clr)  alarm_q <= 1'b0;
      else if (fire)  alarm_q <= ~alarm_q;

      if (rearm)                    arm_under <= 1'b0;
      else if (fire && latch_mode)  arm_under <= ~arm_under;
    end
  end
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl #(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic [LIM_W-1:0]  lim_high,
  input  logic [LIM_W-1:0]  lim_hyst,
  input  logic              cfg_latch_mode,
  input  logic              cfg_active_high,
  input  logic [1:0]        cfg_fault_code,
  input  logic              reg_read,
  input  logic              cfg_shutdown,
  output logic              alarm,
  output logic              pin_pull_low
);
  import talm_pkg::*;

  logic mode_q, mode_chg;
  logic above, under, cond, eval, fire, latch_clr;
  logic alarm_q, arm_under;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= cfg_latch_mode;
  end
  assign mode_chg = cfg_latch_mode != mode_q;

  talm_limit_cmp #(.TEMP_W(TEMP_W), .LIM_W(LIM_W)) u_cmp (
    .temp(conv_temp), .hi(lim_high), .lo(lim_hyst),
    .above(above), .under(under)
  );

  // Condition in force: thermostat follows the alarm, latched follows the arm bit.
  assign cond = (cfg_latch_mode ? arm_under : alarm_q) ? under : above;
  assign eval = conv_valid && !cfg_shutdown && !mode_chg &&
                !(cfg_latch_mode && alarm_q);
  assign latch_clr = cfg_latch_mode && alarm_q && (reg_read || cfg_shutdown) &&
                     !mode_chg;

  talm_fault_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .qualify(eval), .hit(cond),
    .force_clr(mode_chg || latch_clr),
    .need(fault_need(cfg_fault_code)),
    .reached(fire)
  );

  talm_alarm_state u_state (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .latch_clr(latch_clr), .rearm(mode_chg),
    .latch_mode(cfg_latch_mode),
    .alarm_q(alarm_q), .arm_under(arm_under)
  );

  assign alarm        = alarm_q;
  assign pin_pull_low = alarm_q ^ cfg_active_high;
endmodule

// File: rtl/talm_checker.sv
module talm_checker #(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_valid,
  input logic [TEMP_W-1:0] conv_temp,
  input logic [LIM_W-1:0]  lim_high,
  input logic              cfg_latch_mode,
  input logic              reg_read,
  input logic              cfg_shutdown,
  input logic              alarm
);
  logic live_above;
  assign live_above = conv_valid && !cfg_shutdown &&
                      ($signed(conv_temp[TEMP_W-1 -: LIM_W]) > $signed(lim_high));

  a_r2_change_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm) |-> $past(conv_valid || reg_read || cfg_shutdown));

  a_r5_thermo_ignores_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch_mode && !(conv_valid && !cfg_shutdown)) |=> $stable(alarm));

  a_r3_no_set_without_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch_mode && !alarm && !live_above) |=> !alarm);

  a_r7_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch_mode && $stable(cfg_latch_mode) && alarm && (reg_read || cfg_shutdown))
      |=> !alarm);

  a_r8_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch_mode && alarm && !reg_read && !cfg_shutdown) |=> alarm);
endmodule

bind thermal_alarm_ctrl talm_checker #(.TEMP_W(TEMP_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_temp(conv_temp),
  .lim_high(lim_high), .cfg_latch_mode(cfg_latch_mode), .reg_read(reg_read),
  .cfg_shutdown(cfg_shutdown), .alarm(alarm)
);

// File: tb/sim_thermal_alarm_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_alarm_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, conv_valid, cfg_latch_mode, cfg_active_high, reg_read, cfg_shutdown;
  logic [10:0] conv_temp;
  logic [8:0]  lim_high, lim_hyst;
  logic [1:0]  cfg_fault_code;
  logic alarm, pin_pull_low;

  thermal_alarm_ctrl u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic m_alarm = 0, m_armlow = 0, m_mode = 0;
  int m_cnt = 0;

  function automatic int need_of(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 6; endcase
  endfunction

  function automatic logic [10:0] temp_of(input int half, input int frac);
    logic [8:0] t9 = 9'(half);
    return {t9, 2'(frac)};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model of one clock edge, written from the requirements.
  task automatic model_step();
    logic signed [8:0] t9, hi, lo;
    logic cond;
    t9 = conv_temp[10:2]; hi = lim_high; lo = lim_hyst;
    if (cfg_latch_mode != m_mode) begin
      m_mode = cfg_latch_mode; m_cnt = 0; m_armlow = 0;
    end else if (m_mode && m_alarm) begin
      if (reg_read || cfg_shutdown) begin m_alarm = 0; m_cnt = 0; end
    end else if (conv_valid && !cfg_shutdown) begin
      cond = (m_mode ? m_armlow : m_alarm) ? (t9 < lo) : (t9 > hi);
      if (cond) begin
        if (m_cnt + 1 >= need_of(cfg_fault_code)) begin
          m_alarm = !m_alarm;
          if (m_mode) m_armlow = !m_armlow;
          m_cnt = 0;
        end else m_cnt++;
      end else m_cnt = 0;
    end
  endtask

  // Called at a negedge with inputs set; returns at the following negedge.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " alarm"}, alarm, m_alarm);
    chk({tag, " pin"}, pin_pull_low, m_alarm ^ cfg_active_high);
    conv_valid = 0; reg_read = 0;
  endtask

  task automatic sample(input string tag, input int half, input int frac);
    conv_valid = 1; conv_temp = temp_of(half, frac);
    cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; conv_valid = 0; conv_temp = '0; reg_read = 0; cfg_shutdown = 0;
    cfg_latch_mode = 0; cfg_active_high = 0; cfg_fault_code = 2'b00;
    lim_high = 9'h0A0; lim_hyst = 9'h096;
    repeat (3) @(negedge clk);
    chk("R1 reset alarm", alarm, 1'b0);
    chk("R1 reset pin", pin_pull_low, 1'b0);
    rst_n = 1;
    @(negedge clk);

    // R2: equality and truncated low bits do not trip
    sample("R2 equal high", 160, 3);
    chk("R2 equal no trip", alarm, 1'b0);
    sample("R3 above high", 161, 0);
    chk("R3 set", alarm, 1'b1);
    chk("R9 active low pulls", pin_pull_low, 1'b1);
    // R5: read and shutdown leave thermostat alarm
    reg_read = 1; cyc("R5 read");
    chk("R5 read keeps", alarm, 1'b1);
    cfg_shutdown = 1; cyc("R5 shutdown");
    sample("R11 sample in shutdown", 100, 0);
    chk("R11 ignored", alarm, 1'b1);
    cfg_shutdown = 0; cyc("R5 wake");
    sample("R4 equal hyst", 150, 0);
    chk("R4 equal no clear", alarm, 1'b1);
    sample("R4 under hyst", 149, 3);
    chk("R4 clear", alarm, 1'b0);

    // R2: negative limits, signed compare
    lim_high = 9'(-20); lim_hyst = 9'(-40);
    sample("R2 neg below", -21, 0);
    chk("R2 neg no trip", alarm, 1'b0);
    sample("R2 neg above", -18, 0);
    chk("R2 neg trip", alarm, 1'b1);
    sample("R4 neg under", -41, 0);
    chk("R4 neg clear", alarm, 1'b0);

    // R6: queue of six with a restart
    lim_high = 9'h0A0; lim_hyst = 9'h096; cfg_fault_code = 2'b11;
    for (int i = 0; i < 3; i++) sample("R6 partial", 170, 0);
    sample("R6 miss", 155, 0);
    for (int i = 0; i < 5; i++) sample("R6 five", 170, 0);
    chk("R6 five no set", alarm, 1'b0);
    sample("R6 sixth", 170, 0);
    chk("R6 six set", alarm, 1'b1);
    cfg_fault_code = 2'b10;
    for (int i = 0; i < 3; i++) sample("R6 clr three", 100, 0);
    chk("R6 three no clear", alarm, 1'b1);
    sample("R6 clr fourth", 100, 0);
    chk("R6 four clear", alarm, 1'b0);

    // R10: mode change drops the partial count
    cfg_fault_code = 2'b01;
    sample("R10 one hit", 170, 0);
    cfg_latch_mode = 1; cyc("R10 switch");
    sample("R10 first after", 170, 0);
    chk("R10 count restarted", alarm, 1'b0);
    sample("R10 second after", 170, 0);
    chk("R7 latched trip", alarm, 1'b1);
    // R8: held while active
    sample("R8 cold sample", 100, 0);
    sample("R8 cold sample", 100, 0);
    chk("R8 held", alarm, 1'b1);
    reg_read = 1; cyc("R7 read clears");
    chk("R7 read clears", alarm, 1'b0);
    cfg_fault_code = 2'b00;
    sample("R7 hot while armed under", 170, 0);
    chk("R7 hot ignored", alarm, 1'b0);
    sample("R7 under trip", 100, 0);
    chk("R7 under sets", alarm, 1'b1);
    cfg_shutdown = 1; cyc("R7 shutdown clears");
    chk("R7 shutdown clears", alarm, 1'b0);
    cfg_shutdown = 0; cyc("R7 wake");
    sample("R7 cold while armed high", 100, 0);
    chk("R7 cold ignored", alarm, 1'b0);
    sample("R7 high again", 170, 0);
    chk("R7 high again", alarm, 1'b1);
    cfg_active_high = 1; #1;
    chk("R9 active high releases", pin_pull_low, 1'b0);
    reg_read = 1; cyc("R9 cleared");
    chk("R9 inactive high pulls", pin_pull_low, 1'b1);

    // Random mix checked against the model (all requirements)
    void'($urandom(32'h5eed_7a11));
    for (int i = 0; i < 4000; i++) begin
      int hi, lo, span;
      if ($urandom_range(49) == 0) cfg_fault_code = 2'($urandom_range(3));
      if ($urandom_range(199) == 0) cfg_latch_mode = !cfg_latch_mode;
      if ($urandom_range(99) == 0) cfg_active_high = !cfg_active_high;
      if ($urandom_range(99) == 0) cfg_shutdown = !cfg_shutdown;
      if ($urandom_range(299) == 0) begin
        hi = int'($urandom_range(300)) - 100;
        lo = hi - 1 - int'($urandom_range(19));
        lim_high = 9'(hi); lim_hyst = 9'(lo);
      end
      hi = int'($signed(lim_high)); lo = int'($signed(lim_hyst));
      span = hi - lo + 6;
      conv_valid = $urandom_range(1);
      conv_temp = temp_of(lo - 3 + int'($urandom_range(span)), int'($urandom_range(3)));
      reg_read = ($urandom_range(9) == 0);
      cyc("R6 random");
    end
    finish_run();
  end
endmodule